// File: doc/BRIEF.md
# Iterative Integer Divide and Multiply Unit

This unit computes 32-bit integer quotients, remainders and products for an execution pipeline. A caller presents a function code with two operands and pulses a start input. Multiplies and rejected codes complete on the next clock edge. Divides run as a bit-serial restoring loop that keeps the unit busy for one cycle per result bit. Completion is marked by a single-cycle done pulse. The result stays on its output until the next completion.

Signed divides work on operand magnitudes and correct the signs after the last iteration. Quotients therefore truncate toward zero. Two operand combinations have fixed answers and never trap: the most-negative value divided by minus one, and any division by zero.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 0 returns the unsigned quotient opa/opb. Function code 1 returns the unsigned remainder opa%opb.
- R2: Function code 2 returns the signed quotient, truncated toward zero. Function code 3 returns the signed remainder, whose sign follows the dividend when it is nonzero.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: When opb is zero, a divide (codes 0 and 2) returns 0xFFFFFFFF and a remainder (codes 1 and 3) returns opa unchanged. No other indication is given.
- R5: Function code 8 returns the low 32 bits of the unsigned product. Function code 9 returns the high 32 bits of the unsigned 64-bit product. In both cases done is high in the cycle after the start edge, and busy stays low.
- R6: An accepted divide or remainder raises busy in the cycle after the start edge. Done and the result appear exactly WIDTH cycles after the start edge. In the same cycle busy falls. Busy and done are never high together.
- R7: Every function code other than 0, 1, 2, 3, 8 and 9 completes in the cycle after the start edge with illegal high and a result of 0. Illegal is high only in a done cycle.
- R8: Done is high for one cycle per accepted operation. The result holds its value in every cycle without done.
- R9: A start raised while busy is ignored. The operation in flight finishes with its own result, and no extra completion follows.
- R10: After reset, done, busy and illegal are low and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; taken only while not busy |
| func_i | input | 4 | Function code |
| opa_i | input | 32 | Dividend or multiplicand |
| opb_i | input | 32 | Divisor or multiplier |
| result_o | output | 32 | Result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A divide is in progress |
| illegal_o | output | 1 | The completing function code was rejected |

## Verification
The bench builds the unit with its default parameters: WIDTH 32 and a 4-bit function code. At this width the signed overflow pair 0x80000000 / 0xFFFFFFFF can be applied directly. A full 32-edge divide loop runs, so the completion cycle of every divide is checked against a cycle count. The 4-bit code covers every unused code up to 15, so the rejection path is exercised on codes close to the valid ones and far from them. Directed corner operands are followed by a long run of random operations. Some of these random operations raise start while a divide is still running.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_DIVU, OP_REMU, OP_DIVS, OP_REMS, OP_MULLO, OP_MULHU, OP_BAD
  } op_e;

  localparam int unsigned FN_DIVU  = 0;
  localparam int unsigned FN_REMU  = 1;
  localparam int unsigned FN_DIVS  = 2;
  localparam int unsigned FN_REMS  = 3;
  localparam int unsigned FN_MULLO = 8;
  localparam int unsigned FN_MULHU = 9;
endpackage

// File: rtl/muldiv_decode.sv
module muldiv_decode
  import muldiv_pkg::*;
#(
  parameter int unsigned FUNC_W = 4
) (
  input  logic [FUNC_W-1:0] func_i,
  output op_e               op_o,
  output logic              is_div_o,
  output logic              is_mul_o,
  output logic              is_signed_o,
  output logic              want_rem_o
);
  always_comb begin
    if      (func_i == FUNC_W'(FN_DIVU))  op_o = OP_DIVU;
    else if (func_i == FUNC_W'(FN_REMU))  op_o = OP_REMU;
    else if (func_i == FUNC_W'(FN_DIVS))  op_o = OP_DIVS;
    else if (func_i == FUNC_W'(FN_REMS))  op_o = OP_REMS;
    else if (func_i == FUNC_W'(FN_MULLO)) op_o = OP_MULLO;
    else if (func_i == FUNC_W'(FN_MULHU)) op_o = OP_MULHU;
    else                                  op_o = OP_BAD;
  end

  assign is_div_o    = (op_o == OP_DIVU) || (op_o == OP_REMU) ||
                       (op_o == OP_DIVS) || (op_o == OP_REMS);
  assign is_mul_o    = (op_o == OP_MULLO) || (op_o == OP_MULHU);
  assign is_signed_o = (op_o == OP_DIVS) || (op_o == OP_REMS);
  assign want_rem_o  = (op_o == OP_REMU) || (op_o == OP_REMS);
endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             hi_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned PW = 2 * WIDTH;
  logic [PW-1:0] prod;

  assign prod  = PW'(a_i) * PW'(b_i);
  assign res_o = hi_i ? prod[PW-1:WIDTH] : prod[WIDTH-1:0];
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sgn_i,
  input  logic             rem_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] quo_q, dvs_q, dvd_raw_q;
  logic [WIDTH:0]   rem_q;
  logic             neg_q_q, neg_r_q, want_rem_q, zero_q;

  logic [WIDTH-1:0] a_mag, b_mag;
  logic [WIDTH:0]   rem_sh, diff, rem_n;
  logic [WIDTH-1:0] quo_n, q_fix, r_fix;
  logic             ge;

  assign a_mag = (sgn_i && a_i[WIDTH-1]) ? (~a_i + 1'b1) : a_i;
  assign b_mag = (sgn_i && b_i[WIDTH-1]) ? (~b_i + 1'b1) : b_i;

  // one restoring step
  assign rem_sh = {rem_q[WIDTH-1:0], quo_q[WIDTH-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign ge     = ~diff[WIDTH];
  assign rem_n  = ge ? diff : rem_sh;
  assign quo_n  = {quo_q[WIDTH-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      quo_q      <= '0;
      rem_q      <= '0;
      dvs_q      <= '0;
      dvd_raw_q  <= '0;
      neg_q_q    <= 1'b0;
      neg_r_q    <= 1'b0;
      want_rem_q <= 1'b0;
      zero_q     <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        quo_q      <= a_mag;
        rem_q      <= '0;
        dvs_q      <= b_mag;
        dvd_raw_q  <= a_i;
        neg_q_q    <= sgn_i && (a_i[WIDTH-1] ^ b_i[WIDTH-1]);
        neg_r_q    <= sgn_i && a_i[WIDTH-1];
        want_rem_q <= rem_i;
        zero_q     <= (b_i == '0);
      end
    end else begin
      quo_q <= quo_n;
      rem_q <= rem_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign q_fix  = neg_q_q ? (~quo_n + 1'b1) : quo_n;
  assign r_fix  = neg_r_q ? (~rem_n[WIDTH-1:0] + 1'b1) : rem_n[WIDTH-1:0];
  assign fin_o  = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;

  always_comb begin
    if (zero_q) res_o = want_rem_q ? dvd_raw_q : '1;
    else        res_o = want_rem_q ? r_fix : q_fix;
  end

  a_r6_loop_runs_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fin_o |=> busy_q);
  a_r9_operands_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fin_o |=> $stable(dvs_q) && $stable(want_rem_q) && $stable(neg_q_q));
  a_r1_partial_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (dvs_q != '0) |-> rem_q < {1'b0, dvs_q});
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned FUNC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              illegal_o
);
  op_e              op;
  logic             is_div, is_mul, is_sgn, want_rem;
  logic             accept, div_busy, div_fin;
  logic [WIDTH-1:0] mul_res, div_res;
  logic [WIDTH-1:0] result_q;
  logic             done_q, illegal_q;

  muldiv_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func_i(func_i), .op_o(op), .is_div_o(is_div), .is_mul_o(is_mul),
    .is_signed_o(is_sgn), .want_rem_o(want_rem)
  );

  muldiv_mul #(.WIDTH(WIDTH)) u_mul (
    .a_i(opa_i), .b_i(opb_i), .hi_i(op == OP_MULHU), .res_o(mul_res)
  );

  assign accept = start_i && !div_busy;

  muldiv_div #(.WIDTH(WIDTH)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept && is_div),
    .sgn_i(is_sgn), .rem_i(want_rem), .a_i(opa_i), .b_i(opb_i),
    .busy_o(div_busy), .fin_o(div_fin), .res_o(div_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q  <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (div_fin) begin
        result_q <= div_res;
        done_q   <= 1'b1;
      end else if (accept && is_mul) begin
        result_q <= mul_res;
        done_q   <= 1'b1;
      end else if (accept && !is_div) begin
        result_q  <= '0;
        done_q    <= 1'b1;
        illegal_q <= 1'b1;
      end
    end
  end

  assign result_o  = result_q;
  assign done_o    = done_q;
  assign busy_o    = div_busy;
  assign illegal_o = illegal_q;

  a_r6_busy_excludes_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  a_r6_div_raises_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && is_div |=> busy_o && !done_o);
  a_r5_mul_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && is_mul |=> done_o && !busy_o && !illegal_o);
  a_r7_illegal_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && (result_o == '0));
  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    func = '0;
  logic [W-1:0]  opa = '0, opb = '0;
  logic [W-1:0]  result;
  logic          done, busy, illegal;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  bit           exp_busy = 0, exp_done = 0, exp_ill = 0;
  logic [W-1:0] exp_res = '0, pend = '0;
  int           cnt = 0;
  string        cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .func_i(func),
    .opa_i(opa), .opb_i(opb), .result_o(result), .done_o(done),
    .busy_o(busy), .illegal_o(illegal)
  );

  function automatic logic [W-1:0] ref_calc(int f, logic [W-1:0] a, logic [W-1:0] b);
    logic [63:0] p;
    int sa, sb;
    sa = a; sb = b;
    p = 64'(a) * 64'(b);
    case (f)
      0: return (b == 0) ? '1 : a / b;
      1: return (b == 0) ? a : a % b;
      2: if (b == 0) return '1;
         else if (a == 32'h8000_0000 && b == '1) return 32'h8000_0000;
         else return W'(sa / sb);
      3: if (b == 0) return a;
         else if (a == 32'h8000_0000 && b == '1) return '0;
         else return W'(sa % sb);
      8: return p[31:0];
      9: return p[63:32];
      default: return '0;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (result !== exp_res || done !== exp_done || busy !== exp_busy || illegal !== exp_ill) begin
      fails++;
      $display("FAIL %s: got res=%h done=%b busy=%b ill=%b, expected res=%h done=%b busy=%b ill=%b",
               cur_tag, result, done, busy, illegal, exp_res, exp_done, exp_busy, exp_ill);
    end
  endtask

  task automatic model_step();
    exp_done = 0;
    exp_ill  = 0;
    if (exp_busy) begin
      cnt--;
      if (cnt == 0) begin
        exp_busy = 0; exp_done = 1; exp_res = pend;
      end
    end else if (start) begin
      if (func <= 3) begin
        exp_busy = 1; cnt = W; pend = ref_calc(func, opa, opb);
      end else if (func == 8 || func == 9) begin
        exp_done = 1; exp_res = ref_calc(func, opa, opb);
      end else begin
        exp_done = 1; exp_ill = 1; exp_res = '0;
      end
    end
  endtask

  task automatic tick(bit s, int f, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    compare();
    start = s; func = 4'(f); opa = a; opb = b;
    model_step();
  endtask

  task automatic run_op(int f, logic [W-1:0] a, logic [W-1:0] b, string tag);
    cur_tag = tag;
    tick(1, f, a, b);
    while (exp_busy) tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cur_tag = "R10";
    tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);

    // R1 unsigned
    run_op(0, 100, 7, "R1");
    run_op(1, 100, 7, "R1");
    run_op(0, 32'hFFFF_FFFF, 3, "R1");
    run_op(1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R1");
    // R2 signed, truncation toward zero
    run_op(2, -100, 7, "R2");
    run_op(3, -100, 7, "R2");
    run_op(3, 100, -7, "R2");
    run_op(2, 100, -7, "R2");
    run_op(2, -100, -7, "R2");
    // R3 overflow pair
    run_op(2, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
    run_op(3, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
    // R4 divide by zero
    run_op(0, 5, 0, "R4");
    run_op(1, 5, 0, "R4");
    run_op(2, -5, 0, "R4");
    run_op(3, -5, 0, "R4");
    // R5 multiply, including back to back
    run_op(8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    run_op(9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    cur_tag = "R5";
    tick(1, 8, 12345, 678);
    tick(1, 9, 32'h8000_0001, 32'h0000_0010);
    tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
    // R7 rejected codes
    run_op(4, 1, 2, "R7");
    run_op(10, 1, 2, "R7");
    run_op(15, 3, 4, "R7");
    // R9 start while busy
    cur_tag = "R9";
    tick(1, 0, 1000, 9);
    for (int i = 0; i < 5; i++) tick(1, 8, 3, 5);
    tick(1, 15, 0, 0);
    while (exp_busy) tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
    // R6/R8 random traffic with overlapping starts
    cur_tag = "R6";
    for (int i = 0; i < 400; i++) begin
      int f;
      logic [W-1:0] a, b;
      int sel;
      sel = $urandom_range(0, 7);
      f = (sel < 4) ? sel : (sel < 6) ? sel + 4 : int'($urandom_range(0, 15));
      a = $urandom;
      b = $urandom;
      case ($urandom_range(0, 9))
        0: b = '0;
        1: b = '1;
        2: a = 32'h8000_0000;
        3: b = $urandom_range(1, 20);
        default: ;
      endcase
      tick($urandom_range(0, 2) != 0, f, a, b);
    end
    while (exp_busy) tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule